// File: doc/BRIEF.md
# Nonvolatile Store and Recall Sequencer

This block is the clocked controller that sits beside a battery-free nonvolatile SRAM. It decides when the whole array is copied into its nonvolatile shadow (a STORE) and when the shadow is copied back into the SRAM (a RECALL). It times each transfer with a cycle counter and gates every SRAM read and write while a transfer is pending or running. It also keeps a flag that records whether the array was written since the last transfer. The array, the nonvolatile cells and the analog supply comparator live elsewhere. Each transfer is modelled as a fixed number of busy cycles that ends with a one-cycle completion pulse.

A STORE can start in three ways. An external request pin can be pulled low; that request first opens a short grace window in which reads and writes already in flight may finish. A one-cycle software command can start one. The supply can also drop below its threshold while automatic store is enabled, and the transfer then runs on stored charge. A RECALL runs whenever the supply comes back after being low, and a software command can also start one. Two further software commands switch automatic store on and off. That setting is saved with a manual store and is reloaded by every completed recall.

All durations are parameters in clock cycles. Reset is synchronous and active high, and it behaves as a fresh power-up.

Top module: `nv_xfer_ctrl`

## Requirements
- R1: Reset drives `busy_n` high, `recall_act` low, `rd_en` low and `wr_en` low. Once reset is released with `pwr_ok` high, `recall_act` is high for exactly T_HRECALL cycles and no access is granted during that time. Access is granted from the next cycle on.
- R2: An automatic store (on supply loss) or a pin-requested store does not run (`busy_n` stays 1) unless at least one write was accepted since the last completed store or recall.
- R3: Pulling `hw_req_n` low with a written array opens a window of exactly T_GRACE cycles. In this window reads are still granted and a write that was already active keeps `wr_en` high. The store begins in the next cycle. A write that starts while `hw_req_n` is low is never granted.
- R4: A store holds `busy_n` at 0 for exactly T_STORE cycles, however it was started, and `xfer_done` is 1 in the last of those cycles.
- R5: If `hw_req_n` is still low when a store completes, no read or write is granted until `hw_req_n` returns high. Access is granted again in the cycle after the pin is seen high.
- R6: While `pwr_ok` is 0 no access is granted. Supply loss with automatic store enabled and a written array starts a store. After any period of low supply, a recall of T_HRECALL cycles starts once `pwr_ok` is 1 again.
- R7: A software store (`sw_store` pulse) runs even when the array was not written. A software recall (`sw_recall` pulse) holds `recall_act` high for exactly T_SRECALL cycles.
- R8: A write strobe (`ce_n`=0 and `we_n`=0) that is already active when reset ends, or when a store or recall ends, is not granted. A write is granted again only after a new transition into the active strobe state.
- R9: Automatic store is enabled after reset. A `sw_auto_off` pulse disables it, so supply loss then runs no store. A `sw_auto_on` pulse enables it again. Commands are accepted only while idle, and off wins over on.
- R10: The automatic-store setting is copied to a saved value when a manual (pin or software) store completes. The saved value starts as enabled, and every completed recall reloads the setting from it.
- R11: Any request that arrives while a store or recall is in progress is dropped, not queued.
- R12: Reads are granted for `ce_n`=0 and `we_n`=1 when idle. An accepted write marks the array as written, and a completed store or recall clears that mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| pwr_ok | input | 1 | Supply above switch threshold |
| hw_req_n | input | 1 | Active-low external store request |
| ce_n | input | 1 | SRAM chip select, active low |
| we_n | input | 1 | SRAM write strobe, active low |
| sw_store | input | 1 | One-cycle software store command |
| sw_recall | input | 1 | One-cycle software recall command |
| sw_auto_on | input | 1 | One-cycle command: enable automatic store |
| sw_auto_off | input | 1 | One-cycle command: disable automatic store |
| busy_n | output | 1 | Low while a store runs (open-drain busy level) |
| recall_act | output | 1 | High while a recall runs |
| xfer_done | output | 1 | Pulse in the last cycle of a completed transfer |
| rd_en | output | 1 | SRAM read granted |
| wr_en | output | 1 | SRAM write granted |

## Verification
The properties assume that all inputs are synchronous to `clk` and free of glitches. They also assume that a software command lasts one cycle, that the strobes move only between clock edges, and that `pwr_ok` does not bounce within a transfer. The bench changes every input just after a falling edge and reads the outputs one nanosecond later, so each input holds steady across the rising edge that samples it. It asserts each command for exactly one cycle and ties the strobe and supply inputs to known levels from the first cycle, which keeps the stimulus inside these assumptions.

// File: rtl/nv_xfer_pkg.sv
package nv_xfer_pkg;

    typedef enum logic [2:0] {
        NV_OFF,
        NV_RECALL,
        NV_IDLE,
        NV_GRACE,
        NV_STORE,
        NV_HOLD
    } nv_state_e;

    typedef struct packed {
        logic store_done;
        logic recall_done;
        logic manual;
    } nv_done_t;

    function automatic int nv_max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    // bits needed to hold t-1
    function automatic int nv_cnt_bits(input int t);
        return (t < 3) ? 1 : $clog2(t);
    endfunction

endpackage

// File: rtl/nv_xfer_fsm.sv
module nv_xfer_fsm
    import nv_xfer_pkg::*;
#(
    parameter int T_STORE   = 750000,
    parameter int T_HRECALL = 1000000,
    parameter int T_SRECALL = 5000,
    parameter int T_GRACE   = 3500
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pwr_ok,
    input  logic      hw_req_n,
    input  logic      sw_store,
    input  logic      sw_recall,
    input  logic      dirty,
    input  logic      auto_en,
    output nv_state_e state,
    output nv_done_t  done,
    output logic      cfg_ok
);
    localparam int CW = nv_cnt_bits(nv_max4(T_STORE, T_HRECALL, T_SRECALL, T_GRACE));

    nv_state_e       state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic            manual_q, manual_d;
    logic            rcl_pend_q;
    logic            tz;

    assign tz = (cnt_q == '0);

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        manual_d = manual_q;
        if (!tz && (state_q == NV_RECALL || state_q == NV_GRACE || state_q == NV_STORE))
            cnt_d = cnt_q - CW'(1);
        case (state_q)
            NV_OFF: begin
                if (pwr_ok) begin
                    state_d = NV_RECALL;
                    cnt_d   = CW'(T_HRECALL - 1);
                end
            end
            NV_RECALL: begin
                if (!pwr_ok)  state_d = NV_OFF;
                else if (tz)  state_d = NV_IDLE;
            end
            NV_IDLE: begin
                if (!pwr_ok) begin
                    if (auto_en && dirty) begin
                        state_d  = NV_STORE;
                        cnt_d    = CW'(T_STORE - 1);
                        manual_d = 1'b0;
                    end else begin
                        state_d = NV_OFF;
                    end
                end else if (!hw_req_n) begin
                    if (dirty) begin
                        state_d = NV_GRACE;
                        cnt_d   = CW'(T_GRACE - 1);
                    end
                end else if (sw_store) begin
                    state_d  = NV_STORE;
                    cnt_d    = CW'(T_STORE - 1);
                    manual_d = 1'b1;
                end else if (sw_recall) begin
                    state_d = NV_RECALL;
                    cnt_d   = CW'(T_SRECALL - 1);
                end
            end
            NV_GRACE: begin
                if (tz) begin
                    state_d  = NV_STORE;
                    cnt_d    = CW'(T_STORE - 1);
                    manual_d = 1'b1;
                end
            end
            NV_STORE: begin
                if (tz) begin
                    if (rcl_pend_q || !pwr_ok) state_d = NV_OFF;
                    else if (!hw_req_n)        state_d = NV_HOLD;
                    else                       state_d = NV_IDLE;
                end
            end
            NV_HOLD: begin
                if (!pwr_ok)       state_d = NV_OFF;
                else if (hw_req_n) state_d = NV_IDLE;
            end
            default: state_d = NV_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= NV_OFF;
            cnt_q      <= '0;
            manual_q   <= 1'b0;
            rcl_pend_q <= 1'b1;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            manual_q <= manual_d;
            if (!pwr_ok)                 rcl_pend_q <= 1'b1;
            else if (state_q == NV_OFF)  rcl_pend_q <= 1'b0;
        end
    end

    assign state            = state_q;
    assign done.store_done  = (state_q == NV_STORE) && tz;
    assign done.recall_done = (state_q == NV_RECALL) && tz && pwr_ok;
    assign done.manual      = manual_q;
    assign cfg_ok           = (state_q == NV_IDLE) && pwr_ok && hw_req_n && !sw_store && !sw_recall;

endmodule

// File: rtl/nv_wr_gate.sv
module nv_wr_gate
    import nv_xfer_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     access_ok,
    input  logic     hw_req_n,
    input  logic     ce_n,
    input  logic     we_n,
    input  nv_done_t done,
    output logic     rd_en,
    output logic     wr_en,
    output logic     dirty
);
    logic wr_act, wr_start;
    logic wr_prev_q, wr_ok_q, dirty_q;

    assign wr_act   = !ce_n && !we_n;
    assign wr_start = wr_act && !wr_prev_q;
    // an ongoing granted write continues; a new one needs a fresh edge and the pin high
    assign wr_en    = access_ok && wr_act && (wr_ok_q || (wr_start && hw_req_n));
    assign rd_en    = access_ok && !ce_n && we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_prev_q <= 1'b1;
            wr_ok_q   <= 1'b0;
            dirty_q   <= 1'b0;
        end else begin
            wr_prev_q <= wr_act;
            wr_ok_q   <= wr_en;
            if (done.store_done || done.recall_done) dirty_q <= 1'b0;
            else if (wr_en)                          dirty_q <= 1'b1;
        end
    end

    assign dirty = dirty_q;

endmodule

// File: rtl/nv_mode_bits.sv
module nv_mode_bits
    import nv_xfer_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cfg_ok,
    input  logic     sw_auto_on,
    input  logic     sw_auto_off,
    input  nv_done_t done,
    output logic     auto_en
);
    logic en_q, saved_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b1;
            saved_q <= 1'b1;
        end else begin
            if (done.recall_done)            en_q <= saved_q;
            else if (cfg_ok && sw_auto_off)  en_q <= 1'b0;
            else if (cfg_ok && sw_auto_on)   en_q <= 1'b1;
            if (done.store_done && done.manual) saved_q <= en_q;
        end
    end

    assign auto_en = en_q;

endmodule

// File: rtl/nv_xfer_ctrl.sv
module nv_xfer_ctrl
    import nv_xfer_pkg::*;
#(
    parameter int T_STORE   = 750000,
    parameter int T_HRECALL = 1000000,
    parameter int T_SRECALL = 5000,
    parameter int T_GRACE   = 3500
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_ok,
    input  logic hw_req_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic sw_store,
    input  logic sw_recall,
    input  logic sw_auto_on,
    input  logic sw_auto_off,
    output logic busy_n,
    output logic recall_act,
    output logic xfer_done,
    output logic rd_en,
    output logic wr_en
);
    nv_state_e state;
    nv_done_t  done;
    logic      cfg_ok, dirty, auto_en, access_ok;

    nv_xfer_fsm #(
        .T_STORE   (T_STORE),
        .T_HRECALL (T_HRECALL),
        .T_SRECALL (T_SRECALL),
        .T_GRACE   (T_GRACE)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .pwr_ok    (pwr_ok),
        .hw_req_n  (hw_req_n),
        .sw_store  (sw_store),
        .sw_recall (sw_recall),
        .dirty     (dirty),
        .auto_en   (auto_en),
        .state     (state),
        .done      (done),
        .cfg_ok    (cfg_ok)
    );

    assign access_ok = pwr_ok && (state == NV_IDLE || state == NV_GRACE);

    nv_wr_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .access_ok (access_ok),
        .hw_req_n  (hw_req_n),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .done      (done),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .dirty     (dirty)
    );

    nv_mode_bits u_mode (
        .clk         (clk),
        .rst         (rst),
        .cfg_ok      (cfg_ok),
        .sw_auto_on  (sw_auto_on),
        .sw_auto_off (sw_auto_off),
        .done        (done),
        .auto_en     (auto_en)
    );

    assign busy_n     = (state != NV_STORE);
    assign recall_act = (state == NV_RECALL);
    assign xfer_done  = done.store_done || done.recall_done;

endmodule

// File: rtl/nv_xfer_chk.sv
module nv_xfer_chk (
    input logic clk,
    input logic rst,
    input logic pwr_ok,
    input logic hw_req_n,
    input logic ce_n,
    input logic we_n,
    input logic sw_store,
    input logic busy_n,
    input logic recall_act,
    input logic xfer_done,
    input logic rd_en,
    input logic wr_en,
    input logic dirty
);
    // R2: a store not commanded by software needs a written array
    assert_store_needs_dirty_R2: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy_n) && !$past(sw_store)) |-> $past(dirty));

    // R3: a write that starts while the request pin is low is never granted
    assert_no_new_write_pin_low_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_en) |-> hw_req_n);

    // R4: busy stays low until the completion pulse
    assert_busy_until_done_R4: assert property (@(posedge clk) disable iff (rst)
        (!busy_n && !xfer_done) |=> !busy_n);

    // R5: store completing with pin low leaves access closed next cycle
    assert_hold_after_store_R5: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && !busy_n && !hw_req_n) |=> (!rd_en && !wr_en));

    // R6: no access while supply is low
    assert_no_access_low_supply_R6: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |-> (!rd_en && !wr_en));

    // R8: a newly granted write follows an inactive strobe cycle
    assert_fresh_edge_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_en) |-> $past(ce_n || we_n));

    // R12: no access during either transfer
    always_comb begin
        if (!rst) begin
            assert_no_access_in_xfer_R12: assert (!((!busy_n || recall_act) && (rd_en || wr_en)));
        end
    end

endmodule

bind nv_xfer_ctrl nv_xfer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .pwr_ok     (pwr_ok),
    .hw_req_n   (hw_req_n),
    .ce_n       (ce_n),
    .we_n       (we_n),
    .sw_store   (sw_store),
    .busy_n     (busy_n),
    .recall_act (recall_act),
    .xfer_done  (xfer_done),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .dirty      (dirty)
);

// File: tb/nv_xfer_ctrl_test.sv
`timescale 1ns/1ps
module nv_xfer_ctrl_test;
    localparam int TS = 10, TH = 12, TR = 6, TG = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_ok = 1'b1, hw_req_n = 1'b1, ce_n = 1'b0, we_n = 1'b1;
    logic sw_store = 1'b0, sw_recall = 1'b0, sw_auto_on = 1'b0, sw_auto_off = 1'b0;
    logic busy_n, recall_act, xfer_done, rd_en, wr_en;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    nv_xfer_ctrl #(.T_STORE(TS), .T_HRECALL(TH), .T_SRECALL(TR), .T_GRACE(TG)) uut (
        .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .hw_req_n(hw_req_n),
        .ce_n(ce_n), .we_n(we_n), .sw_store(sw_store), .sw_recall(sw_recall),
        .sw_auto_on(sw_auto_on), .sw_auto_off(sw_auto_off),
        .busy_n(busy_n), .recall_act(recall_act), .xfer_done(xfer_done),
        .rd_en(rd_en), .wr_en(wr_en)
    );

    // {ce_n, we_n, expected rd_en, expected wr_en}, one row per cycle, idle state
    localparam logic [3:0] VEC [7] = '{
        4'b1100, 4'b0110, 4'b0001, 4'b0001, 4'b1000, 4'b0001, 4'b1100
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        #1;
    endtask

    task automatic run_len(input bit rec, output int n, output bit leak, output bit last_done);
        n = 0; leak = 1'b0; last_done = 1'b0;
        while ((rec ? recall_act : !busy_n) && n < 500) begin
            n++;
            leak = leak | rd_en | wr_en;
            last_done = xfer_done;
            cyc();
        end
    endtask

    task automatic do_write(input string tag);
        we_n = 1'b0; #1;
        chk(tag, wr_en, 1);
        cyc();
        we_n = 1'b1;
        cyc();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n; bit lk; bit dn;
        // R1 reset state
        repeat (3) cyc();
        chk("R1 reset busy_n", busy_n, 1);
        chk("R1 reset recall_act", recall_act, 0);
        chk("R1 reset rd_en", rd_en, 0);
        rst = 1'b0;
        cyc();
        chk("R1 recall starts", recall_act, 1);
        run_len(1'b1, n, lk, dn);
        chk("R1 power-up recall length", n, TH);
        chk("R1 no access in recall", lk, 0);
        chk("R1 read after recall", rd_en, 1);

        // R12 / R8 vector walk
        for (int i = 0; i < 7; i++) begin
            ce_n = VEC[i][3]; we_n = VEC[i][2]; #1;
            chk($sformatf("R12 R8 vec%0d rd_en", i), rd_en, VEC[i][1]);
            chk($sformatf("R12 R8 vec%0d wr_en", i), wr_en, VEC[i][0]);
            cyc();
        end

        // R4 / R11: software store, recall command during store dropped
        sw_store = 1'b1; cyc();
        sw_store = 1'b0; sw_recall = 1'b1;
        chk("R4 store busy", busy_n, 0);
        cyc();
        sw_recall = 1'b0;
        ce_n = 1'b0; we_n = 1'b1;
        run_len(1'b0, n, lk, dn);
        chk("R4 store length", n + 1, TS);
        chk("R4 done in last cycle", dn, 1);
        chk("R11 recall not queued", recall_act, 0);
        chk("R12 read after store", rd_en, 1);

        // R2 / R3: pin low with clean array, no store, reads go on, new write blocked
        hw_req_n = 1'b0;
        cyc(); cyc(); cyc();
        chk("R2 clean pin request skipped", busy_n, 1);
        chk("R3 read while pin low", rd_en, 1);
        we_n = 1'b0; #1;
        chk("R3 write blocked while pin low", wr_en, 0);
        cyc();
        we_n = 1'b1; hw_req_n = 1'b1;
        cyc();

        // R7: software store on clean array, software recall length
        sw_store = 1'b1; cyc(); sw_store = 1'b0;
        chk("R7 clean software store runs", busy_n, 0);
        run_len(1'b0, n, lk, dn);
        chk("R7 software store length", n, TS);
        sw_recall = 1'b1; cyc(); sw_recall = 1'b0;
        chk("R7 software recall runs", recall_act, 1);
        run_len(1'b1, n, lk, dn);
        chk("R7 software recall length", n, TR);

        // R3 / R5: grace window then hold
        we_n = 1'b0; #1;
        chk("R12 write accepted", wr_en, 1);
        cyc();
        hw_req_n = 1'b0; #1;
        chk("R3 ongoing write at pin fall", wr_en, 1);
        cyc();
        chk("R3 ongoing write in grace", wr_en, 1);
        chk("R3 no busy in grace", busy_n, 1);
        we_n = 1'b1; #1;
        chk("R3 read in grace", rd_en, 1);
        cyc();
        we_n = 1'b0; #1;
        chk("R3 new write in grace blocked", wr_en, 0);
        cyc();
        we_n = 1'b1;
        cyc();
        chk("R3 grace last cycle", busy_n, 1);
        cyc();
        chk("R3 store after grace", busy_n, 0);
        run_len(1'b0, n, lk, dn);
        chk("R4 pin store length", n, TS);
        chk("R5 hold after store", rd_en, 0);
        cyc();
        chk("R5 still held", rd_en, 0);
        hw_req_n = 1'b1;
        cyc();
        chk("R5 released", rd_en, 1);
        hw_req_n = 1'b0;
        cyc(); cyc();
        chk("R12 mark cleared by store", busy_n, 1);
        hw_req_n = 1'b1;
        cyc();

        // R6: automatic store on supply loss, then recall
        do_write("R12 write before loss");
        pwr_ok = 1'b0;
        cyc();
        chk("R6 auto store", busy_n, 0);
        run_len(1'b0, n, lk, dn);
        chk("R6 auto store length", n, TS);
        chk("R6 no recall while low", recall_act, 0);
        chk("R6 no access while low", rd_en, 0);
        cyc();
        pwr_ok = 1'b1;
        cyc();
        run_len(1'b1, n, lk, dn);
        chk("R6 recall after loss", n, TH);

        // R2 / R8: loss with clean array; strobes held through recall
        pwr_ok = 1'b0;
        cyc();
        chk("R2 clean loss no store", busy_n, 1);
        we_n = 1'b0;
        cyc();
        pwr_ok = 1'b1;
        cyc();
        run_len(1'b1, n, lk, dn);
        chk("R8 held strobe not granted", wr_en, 0);
        we_n = 1'b1;
        cyc();
        we_n = 1'b0; #1;
        chk("R8 fresh edge granted", wr_en, 1);
        cyc();
        we_n = 1'b1;
        cyc();

        // R9: disable blocks auto store; R10: recall restores saved enable
        sw_auto_off = 1'b1; cyc(); sw_auto_off = 1'b0;
        pwr_ok = 1'b0;
        cyc();
        chk("R9 disabled no store", busy_n, 1);
        cyc();
        pwr_ok = 1'b1;
        cyc();
        run_len(1'b1, n, lk, dn);
        do_write("R12 write after recall");
        pwr_ok = 1'b0;
        cyc();
        chk("R10 enable reloaded", busy_n, 0);
        run_len(1'b0, n, lk, dn);
        pwr_ok = 1'b1;
        cyc();
        run_len(1'b1, n, lk, dn);

        // R10: disable saved by manual store persists across a power cycle
        sw_auto_off = 1'b1; cyc(); sw_auto_off = 1'b0;
        sw_store = 1'b1; cyc(); sw_store = 1'b0;
        run_len(1'b0, n, lk, dn);
        pwr_ok = 1'b0; cyc();
        pwr_ok = 1'b1; cyc();
        run_len(1'b1, n, lk, dn);
        do_write("R12 write persisted case");
        pwr_ok = 1'b0;
        cyc();
        chk("R10 disable persisted", busy_n, 1);
        pwr_ok = 1'b1;
        cyc();
        run_len(1'b1, n, lk, dn);
        sw_auto_on = 1'b1; cyc(); sw_auto_on = 1'b0;
        do_write("R12 write after enable");
        pwr_ok = 1'b0;
        cyc();
        chk("R9 enable restores auto store", busy_n, 0);
        run_len(1'b0, n, lk, dn);
        pwr_ok = 1'b1;
        cyc();
        run_len(1'b1, n, lk, dn);
        chk("R6 final recall length", n, TH);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule